// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host reach a byte-wide asynchronous static RAM. The host hands over one request at a time on a valid/ready port. A request carries a 19-bit address, an 8-bit write value and a direction flag. The controller then runs one complete RAM cycle by moving three active-low strobes: chip select, write strobe and output enable. It drives the address and the write data toward the pads, and it raises a one-cycle response strobe that carries the byte fetched by a read.

The RAM has no clock, so every time window it needs becomes a whole number of controller cycles. The counts come from a clock-period parameter and the nanosecond limits of a 55 ns part, rounded up, with at least one cycle per phase. At the default 5 ns clock the counts are:

| Phase | Cycles |
|---|---|
| Setup | 4 |
| Write strobe | 9 |
| Write hold | 1 |
| Read wait | 6 |
| Read sample | 1 |

The controller orders its strobe edges so that:
- the write strobe falls and rises inside a stable address and data window;
- the controller never drives the shared data lines while the RAM may still be driving them after a read.

Between requests, chip select returns high so the RAM drops into standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and just after it is released, chip select, write strobe and output enable are all high, the pad drive enable is low, `req_ready` is high and `rsp_valid` is low. An asynchronous reset taken in the middle of a cycle forces the same state at once.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no RAM cycle is in progress, and it is low for every cycle in which chip select is low.
- R3: A write holds chip select low for 14 cycles. During the first 4 of those cycles the write strobe is high. The write strobe is then low for 9 cycles in a row (at least 45 ns). Output enable stays high for the whole write.
- R4: While chip select is low, the RAM address equals the accepted request address. While the pads are driven, the write data equals the accepted write value. Changes on the host request inputs during a cycle have no effect on either.
- R5: The pad drive enable is high only while chip select is low and output enable is high. It is high for exactly the 10 cycles of the write strobe and hold phases. It is never high until output enable has been high for at least 4 cycles (20 ns).
- R6: The write strobe rises exactly one cycle before chip select rises. The write data stays driven through that cycle.
- R7: A read holds chip select low for 11 cycles. Output enable is low from the 5th of those cycles to the last one, 7 cycles in all. The byte on `sram_dq_in` at the end of the last cycle is returned on `rsp_rdata`, with `rsp_valid` high for exactly the next cycle.
- R8: The write strobe and output enable are never low at the same time.
- R9: Chip select is high whenever no cycle is in progress, so that the RAM is in standby. At least one cycle of chip select high separates two RAM cycles.
- R10: Every RAM cycle keeps chip select low for at least 11 cycles (55 ns).
- R11: A request held valid while a cycle ends is accepted in the first idle cycle. In that case chip select is high for exactly one cycle between the two RAM cycles, and the `rsp_valid` of a finishing read falls in that same idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read byte available |
| rsp_rdata | output | 8 | Byte fetched by the last read |
| sram_addr | output | 19 | Address toward the RAM |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Write byte toward the pads |
| sram_dq_oe | output | 1 | Pad drive enable, active high |
| sram_dq_in | input | 8 | Byte received from the pads |

## Verification
The read response of one request and the acceptance of the next request can fall in the same idle cycle. The bench provokes this by keeping a write request valid while a read is still running. It then judges three things at the ports:
- In the single cycle where chip select is high, `rsp_valid` is high with the expected byte and `req_ready` is high.
- Chip select falls again on the next edge.
- The write data is not driven until output enable has been high long enough for the RAM to release the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SETUP     = 3'd1,
    ST_WR_PULSE  = 3'd2,
    ST_WR_HOLD   = 3'd3,
    ST_RD_WAIT   = 3'd4,
    ST_RD_SAMPLE = 3'd5
  } ctrl_state_e;

  // Ceiling division of a time window by the clock period, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_SU   = 4,
  parameter int N_WP   = 9,
  parameter int N_HOLD = 1,
  parameter int N_RDW  = 6,
  parameter int CNT_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  output ctrl_state_e state_o,
  output logic        ce_n,
  output logic        we_n,
  output logic        oe_n,
  output logic        dq_oe
);

  ctrl_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_done;

  logic ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  assign phase_done = (cnt_q == '0);

  // Next-state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = phase_done ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = CNT_W'(N_SU - 1);
        end
      end
      ST_SETUP: begin
        if (phase_done) begin
          if (is_write) begin
            state_d = ST_WR_PULSE;
            cnt_d   = CNT_W'(N_WP - 1);
          end else begin
            state_d = ST_RD_WAIT;
            cnt_d   = CNT_W'(N_RDW - 1);
          end
        end
      end
      ST_WR_PULSE: begin
        if (phase_done) begin
          state_d = ST_WR_HOLD;
          cnt_d   = CNT_W'(N_HOLD - 1);
        end
      end
      ST_WR_HOLD: begin
        if (phase_done) state_d = ST_IDLE;
      end
      ST_RD_WAIT: begin
        if (phase_done) begin
          state_d = ST_RD_SAMPLE;
          cnt_d   = '0;
        end
      end
      ST_RD_SAMPLE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // Strobes decoded from the next state, then registered so pins never glitch
  always_comb begin
    ce_n_d  = (state_d == ST_IDLE);
    we_n_d  = (state_d != ST_WR_PULSE);
    oe_n_d  = !((state_d == ST_RD_WAIT) || (state_d == ST_RD_SAMPLE));
    dq_oe_d = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign state_o = state_q;
  assign ce_n    = ce_n_q;
  assign we_n    = we_n_q;
  assign oe_n    = oe_n_q;
  assign dq_oe   = dq_oe_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              write_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              write_q, write_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q, rvld_d;

  // Request latch loads only on acceptance; read capture only on the sample edge
  always_comb begin
    addr_d  = accept ? req_addr  : addr_q;
    wdata_d = accept ? req_wdata : wdata_q;
    write_d = accept ? req_write : write_q;
    rdata_d = sample_en ? dq_in : rdata_q;
    rvld_d  = sample_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      write_q <= write_d;
      rdata_q <= rdata_d;
      rvld_q  <= rvld_d;
    end
  end

  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign write_o     = write_q;
  assign rsp_valid_o = rvld_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_WPULSE_NS   = 45,
  parameter int T_WDATA_NS    = 25,
  parameter int T_OE_ACC_NS   = 25,
  parameter int T_TURN_NS     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int C_CYCLE = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int N_SU    = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
  localparam int N_HOLD  = 1;
  localparam int N_WP    = max3(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_WDATA_NS, CLK_PERIOD_NS),
                                C_CYCLE - N_SU - N_HOLD);
  localparam int N_RDW   = max3(1, C_CYCLE - N_SU - 1,
                                ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS) - 1);
  localparam int N_MAX   = max3(N_SU, N_WP, N_RDW);
  localparam int CNT_W   = $clog2(N_MAX + 1);

  ctrl_state_e state;
  logic        accept;
  logic        sample_en;
  logic        write_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign sample_en = (state == ST_RD_SAMPLE);

  sram_ctrl_seq #(
    .N_SU   (N_SU),
    .N_WP   (N_WP),
    .N_HOLD (N_HOLD),
    .N_RDW  (N_RDW),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .is_write (write_q),
    .state_o  (state),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_ctrl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_write   (req_write),
    .sample_en   (sample_en),
    .dq_in       (sram_dq_in),
    .addr_o      (sram_addr),
    .wdata_o     (sram_dq_out),
    .write_o     (write_q),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_TURN_NS     = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              req_ready,
  input logic              rsp_valid
);

  localparam int TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
  localparam int TW       = $clog2(TURN_CYC + 1);

  // Cycles since output enable was last low, saturating
  logic [TW-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   oe_hi_cnt <= TW'(TURN_CYC);
    else if (!oe_n)               oe_hi_cnt <= '0;
    else if (oe_hi_cnt < TW'(TURN_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  p_no_we_with_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && !ce_n));

  p_bus_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_hi_cnt >= TW'(TURN_CYC)));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  p_we_before_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(we_n));

  p_ready_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!oe_n));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_TURN_NS     (T_TURN_NS)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (sram_ce_n),
  .we_n      (sram_we_n),
  .oe_n      (sram_oe_n),
  .dq_oe     (sram_dq_oe),
  .addr      (sram_addr),
  .dq_out    (sram_dq_out),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] sram_addr;
  logic        sram_ce_n;
  logic        sram_we_n;
  logic        sram_oe_n;
  logic [7:0]  sram_dq_out;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_in;

  int tests_run = 0;
  int tests_failed = 0;

  sram_async_ctrl i_sram_async_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_in  (sram_dq_in)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural RAM indexed by the low address byte
  logic [7:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  end
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] <= sram_dq_out;
  end
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'h00;

  // Expected cycle counts at a 5 ns clock
  localparam int E_SU    = 4;
  localparam int E_WP    = 9;
  localparam int E_WR_CE = 14;
  localparam int E_RD_CE = 11;
  localparam int E_RD_OE = 7;

  // {write, addr[18:0], data[7:0]}; for a read, data is the expected byte
  localparam int NVEC = 9;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h12345, 8'hFF},
    {1'b0, 19'h00000, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h12345, 8'h00},
    {1'b0, 19'h12345, 8'h00},
    {1'b1, 19'h5A5A5, 8'h81},
    {1'b0, 19'h5A5A5, 8'h81}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
  endtask

  // One transaction, profiled cycle by cycle at the falling edge
  task automatic run_txn(input logic wr, input logic [18:0] a, input logic [7:0] d);
    int idx, ce_lo, we_lo, we_first, oe_lo, oe_first, dq_cnt;
    int addr_bad, data_bad, busy_rdy, both_low;
    idx = 0; ce_lo = 0; we_lo = 0; we_first = -1; oe_lo = 0; oe_first = -1;
    dq_cnt = 0; addr_bad = 0; data_bad = 0; busy_rdy = 0; both_low = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    chk("R2 ready while idle", int'(req_ready), 1);
    @(negedge clk);
    // host inputs scrambled during the cycle must not matter
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    while (sram_ce_n == 1'b0 && idx < 64) begin
      ce_lo++;
      if (!sram_we_n) begin we_lo++; if (we_first < 0) we_first = idx; end
      if (!sram_oe_n) begin oe_lo++; if (oe_first < 0) oe_first = idx; end
      if (!sram_we_n && !sram_oe_n) both_low++;
      if (sram_addr != a) addr_bad++;
      if (sram_dq_oe) begin dq_cnt++; if (sram_dq_out != d) data_bad++; end
      if (req_ready) busy_rdy++;
      idx++;
      @(negedge clk);
    end
    chk("R4 address held", addr_bad, 0);
    chk("R2 not ready while busy", busy_rdy, 0);
    chk("R8 no we with oe", both_low, 0);
    chk("R10 minimum cycle", int'(ce_lo >= 11), 1);
    chk("R9 standby after cycle", int'(sram_ce_n), 1);
    if (wr) begin
      chk("R3 write ce length", ce_lo, E_WR_CE);
      chk("R3 we low length", we_lo, E_WP);
      chk("R3 we fall index", we_first, E_SU);
      chk("R3 oe high in write", oe_lo, 0);
      chk("R5 drive length", dq_cnt, E_WP + 1);
      chk("R4 write data held", data_bad, 0);
      chk("R6 hold after we", ce_lo - (we_first + we_lo), 1);
      chk("R7 no rsp on write", int'(rsp_valid), 0);
    end else begin
      chk("R7 read ce length", ce_lo, E_RD_CE);
      chk("R7 oe low length", oe_lo, E_RD_OE);
      chk("R7 oe fall index", oe_first, E_SU);
      chk("R5 no drive in read", dq_cnt, 0);
      chk("R7 rsp valid", int'(rsp_valid), 1);
      chk("R7 rsp data", int'(rsp_rdata), int'(d));
      @(negedge clk);
      chk("R7 rsp one cycle", int'(rsp_valid), 0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    int gap, dq_early;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce high in reset", int'(sram_ce_n), 1);
    chk("R1 we high in reset", int'(sram_we_n), 1);
    chk("R1 oe high in reset", int'(sram_oe_n), 1);
    chk("R1 no drive in reset", int'(sram_dq_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 rsp low after reset", int'(rsp_valid), 0);

    // Table-driven traffic
    for (int v = 0; v < NVEC; v++) begin
      run_txn(VEC[v][27], VEC[v][26:8], VEC[v][7:0]);
      idle_inputs();
    end

    // R11: read finishing while a write is queued
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00000; req_wdata = 8'h00;
    @(negedge clk);
    req_write = 1'b1; req_addr = 19'h000C3; req_wdata = 8'h6E;
    while (sram_ce_n == 1'b0) @(negedge clk);
    chk("R11 rsp in gap cycle", int'(rsp_valid), 1);
    chk("R11 rsp data in gap", int'(rsp_rdata), 8'hA5);
    chk("R11 ready in gap", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 single idle cycle", int'(sram_ce_n), 0);
    chk("R11 address of queued write", int'(sram_addr), 19'h000C3);
    gap = 0; dq_early = 0;
    while (sram_ce_n == 1'b0) begin
      if (sram_dq_oe && gap < E_SU) dq_early++;
      gap++;
      @(negedge clk);
    end
    chk("R5 no early drive after read", dq_early, 0);
    chk("R11 queued write length", gap, E_WR_CE);
    idle_inputs();
    run_txn(1'b0, 19'h000C3, 8'h6E);
    idle_inputs();

    // R1: asynchronous reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00011; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 we low mid pulse", int'(sram_we_n), 0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset ce", int'(sram_ce_n), 1);
    chk("R1 async reset we", int'(sram_we_n), 1);
    chk("R1 async reset drive", int'(sram_dq_oe), 0);
    chk("R1 async reset ready", int'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    run_txn(1'b0, 19'h7FFFF, 8'h3C);
    idle_inputs();

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule